// File: doc/BRIEF.md
# Interrupt Priority Resolver with Acknowledge Latch

This block watches the request, enable and level inputs of a set of maskable interrupt groups and keeps the processor informed of the most urgent pending one. A group is pending when at least one of its request lines is set together with the matching enable line. The block scans every eligible group on every cycle. It presents the level of the winner on a registered output. Level 7 means that nothing is pending.

When the processor takes an interrupt it pulses an acknowledge input and returns the level it accepted. The block then captures the number of the group it was presenting into an accepted-group register. The processor reads that register over a small byte-wide read port. If the captured level does not match the level on the output, a one-cycle error flag fires.

Top module: `prio_resolver`

## Requirements
- R1: Only groups 2 to 30 can be selected. A group is a candidate when the AND of its four request bits and its four enable bits is nonzero. Groups 0 and 1 never affect the level output, whatever their inputs.
- R2: Among the candidates, the one with the numerically smallest 3-bit level is selected. When there is no candidate the level output is 7, so a candidate whose level is 7 leaves the output at 7.
- R3: When several candidates share the best level, the one with the lowest group number is selected.
- R4: `lvl_o` is registered. It shows the selection made from the inputs present at the preceding rising clock edge.
- R5: At a rising edge with `ack_i` high, the group number that belongs to the current `lvl_o` is stored in the accepted-group register. When nothing is pending, that group number is 0.
- R6: A read strobe with `rd_addr_i` = 0 returns `rdata_o` one cycle later. The value is the accepted group number shifted left by two, or 0 if that group is no longer a candidate at the time of the strobe. `rdata_o` is 0 in every cycle that follows a cycle with no read strobe.
- R7: A read with `rd_addr_i` = 1 returns 0.
- R8: Write strobes and write data have no effect on the accepted-group register or on any output.
- R9: `ack_err_o` goes high for exactly one cycle after an acknowledge whose `ack_lvl_i` differs from the `lvl_o` at that edge. It stays low after an acknowledge whose level matches.
- R10: While `rst` is high and after it falls, `lvl_o` is 7, the accepted-group register is 0, and `ack_err_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grp_req_i | input | 124 | Request bits, four per group, group g at bits 4g+3..4g |
| grp_en_i | input | 124 | Enable bits, same layout as the requests |
| grp_lvl_i | input | 93 | Level per group, group g at bits 3g+2..3g |
| lvl_o | output | 3 | Registered level of the selected group, 7 when idle |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| ack_lvl_i | input | 3 | Level the processor accepted |
| ack_err_o | output | 1 | One-cycle flag for an acknowledged level that does not match |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Byte select of the accepted-group register |
| rdata_o | output | 8 | Registered read data |
| wr_i | input | 1 | Write strobe, ignored |
| wdata_i | input | 8 | Write data, ignored |

## Verification
The level output is due one rising edge after the inputs change. The acknowledge capture and the error flag are due one edge after `ack_i`. Read data appears one edge after the strobe and is computed from the accepted value held before that same edge. The bench drives every input shortly after a falling edge. Its behavioural model updates at each rising edge using the values that were in place before the edge, and all three outputs are compared at the next falling edge. Directed checks wait exactly one edge after their stimulus before sampling, so a result that arrives a cycle early or late is reported.

// File: rtl/prio_pkg.sv
package prio_pkg;

  // Byte select inside the accepted-group register
  typedef enum logic [0:0] {
    ACC_BYTE_GRP  = 1'b0,
    ACC_BYTE_ZERO = 1'b1
  } acc_byte_e;

endpackage

// File: rtl/prio_select.sv
module prio_select #(
  parameter int NUM_GRP = 31,
  parameter int FIRST_G = 2,
  parameter int LAST_G  = 30,
  parameter int SUB_W   = 4,
  parameter int LVL_W   = 3,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic [NUM_GRP*SUB_W-1:0] req_i,
  input  logic [NUM_GRP*SUB_W-1:0] en_i,
  input  logic [NUM_GRP*LVL_W-1:0] lvl_i,
  output logic [NUM_GRP-1:0]       cand_o,
  output logic [GRP_W-1:0]         sel_grp_o,
  output logic [LVL_W-1:0]         sel_lvl_o
);

  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  logic [NUM_GRP-1:0] unused_grp;

  // Candidate detection per group; groups outside the window are tied off
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cand
    if (g >= FIRST_G && g <= LAST_G) begin : g_in
      assign cand_o[g]     = |(req_i[g*SUB_W +: SUB_W] & en_i[g*SUB_W +: SUB_W]);
      assign unused_grp[g] = 1'b0;
    end else begin : g_out
      assign cand_o[g]     = 1'b0;
      assign unused_grp[g] = ^{req_i[g*SUB_W +: SUB_W], en_i[g*SUB_W +: SUB_W],
                               lvl_i[g*LVL_W +: LVL_W]};
    end
  end

  // Linear scan; strict compare keeps the lowest group on a tie
  always_comb begin
    sel_lvl_o = IDLE_LVL;
    sel_grp_o = '0;
    for (int g = FIRST_G; g <= LAST_G; g++) begin
      if (cand_o[g] && (lvl_i[g*LVL_W +: LVL_W] < sel_lvl_o)) begin
        sel_lvl_o = lvl_i[g*LVL_W +: LVL_W];
        sel_grp_o = GRP_W'(g);
      end
    end
  end

endmodule

// File: rtl/prio_accept.sv
module prio_accept
  import prio_pkg::*;
#(
  parameter int NUM_GRP = 31,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 8,
  localparam int GRP_W  = $clog2(NUM_GRP),
  localparam int PAD_N  = 1 << GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  input  logic [GRP_W-1:0]  cur_grp_i,
  input  logic [LVL_W-1:0]  cur_lvl_i,
  input  logic [NUM_GRP-1:0] cand_i,
  input  logic              rd_i,
  input  logic              rd_addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [GRP_W-1:0]  acc_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [GRP_W-1:0]  acc_q;
  logic [PAD_N-1:0]  cand_pad;
  logic              acc_live;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wr;

  assign unused_wr = ^{wr_i, wdata_i};
  assign cand_pad  = PAD_N'(cand_i);
  assign acc_live  = cand_pad[acc_q];

  always_comb begin
    rd_val = '0;
    if (acc_byte_e'(rd_addr_i) == ACC_BYTE_GRP && acc_live)
      rd_val = DATA_W'({acc_q, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (ack_i) acc_q <= cur_grp_i;
      err_o   <= ack_i && (ack_lvl_i != cur_lvl_i);
      rdata_o <= rd_i ? rd_val : '0;
    end
  end

  assign acc_o = acc_q;

  AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> (acc_q == $past(cur_grp_i)));                      // R5
  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> $stable(acc_q));                                   // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ack_lvl_i == cur_lvl_i) |=> !err_o);                // R9
  AST_BYTE1_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rd_addr_i) |=> (rdata_o == '0));                     // R7
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0));                                   // R6

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_GRP = 31,
  parameter int FIRST_G = 2,
  parameter int LAST_G  = 30,
  parameter int SUB_W   = 4,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 8,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_GRP*SUB_W-1:0] grp_req_i,
  input  logic [NUM_GRP*SUB_W-1:0] grp_en_i,
  input  logic [NUM_GRP*LVL_W-1:0] grp_lvl_i,
  output logic [LVL_W-1:0]         lvl_o,
  input  logic                     ack_i,
  input  logic [LVL_W-1:0]         ack_lvl_i,
  output logic                     ack_err_o,
  input  logic                     rd_i,
  input  logic                     rd_addr_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i
);

  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  logic [NUM_GRP-1:0] cand;
  logic [GRP_W-1:0]   sel_grp;
  logic [LVL_W-1:0]   sel_lvl;
  logic [GRP_W-1:0]   grp_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [GRP_W-1:0]   acc;

  prio_select #(
    .NUM_GRP(NUM_GRP), .FIRST_G(FIRST_G), .LAST_G(LAST_G),
    .SUB_W(SUB_W), .LVL_W(LVL_W)
  ) i_select (
    .req_i     (grp_req_i),
    .en_i      (grp_en_i),
    .lvl_i     (grp_lvl_i),
    .cand_o    (cand),
    .sel_grp_o (sel_grp),
    .sel_lvl_o (sel_lvl)
  );

  // One register stage on the selection
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
      lvl_q <= IDLE_LVL;
    end else begin
      grp_q <= sel_grp;
      lvl_q <= sel_lvl;
    end
  end

  assign lvl_o = lvl_q;

  prio_accept #(
    .NUM_GRP(NUM_GRP), .LVL_W(LVL_W), .DATA_W(DATA_W)
  ) i_accept (
    .clk       (clk),
    .rst       (rst),
    .ack_i     (ack_i),
    .ack_lvl_i (ack_lvl_i),
    .cur_grp_i (grp_q),
    .cur_lvl_i (lvl_q),
    .cand_i    (cand),
    .rd_i      (rd_i),
    .rd_addr_i (rd_addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .acc_o     (acc),
    .err_o     (ack_err_o),
    .rdata_o   (rdata_o)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cand == '0) |=> (lvl_o == IDLE_LVL));                        // R2
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    (sel_lvl != IDLE_LVL) |-> cand[sel_grp]);                     // R1
  AST_WINNER_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (lvl_o != IDLE_LVL) |-> (grp_q >= GRP_W'(FIRST_G) && grp_q <= GRP_W'(LAST_G))); // R1
  AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (acc == '0) || (acc >= GRP_W'(FIRST_G) && acc <= GRP_W'(LAST_G)));  // R5
  AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_err_o |-> $past(ack_i));                                  // R9

endmodule

// File: tb/test_prio_resolver.sv
module test_prio_resolver;

  localparam int CLK_PER = 10;
  localparam int NG = 31;
  localparam int SW = 4;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NG*SW-1:0] req_v = '0;
  logic [NG*SW-1:0] en_v  = '0;
  logic [NG*LW-1:0] lvl_v = '1;
  logic [LW-1:0] lvl_o;
  logic ack = 1'b0;
  logic [LW-1:0] ack_lvl = '0;
  logic ack_err;
  logic rd = 1'b0;
  logic rd_addr = 1'b0;
  logic [7:0] rdata;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R10";

  // behavioural model state
  int m_sel = 0, m_lvl = 7, m_acc = 0, m_err = 0, m_rd = 0;

  always #(CLK_PER/2) clk = ~clk;

  prio_resolver i_prio_resolver (
    .clk(clk), .rst(rst), .grp_req_i(req_v), .grp_en_i(en_v), .grp_lvl_i(lvl_v),
    .lvl_o(lvl_o), .ack_i(ack), .ack_lvl_i(ack_lvl), .ack_err_o(ack_err),
    .rd_i(rd), .rd_addr_i(rd_addr), .rdata_o(rdata), .wr_i(wr), .wdata_i(wdata)
  );

  function automatic bit is_cand(int g);
    if (g < 2 || g > 30) return 1'b0;
    return |(req_v[g*SW +: SW] & en_v[g*SW +: SW]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_lvl = 7; m_acc = 0; m_err = 0; m_rd = 0;
    end else begin
      int bl, bg;
      m_rd  = (rd && !rd_addr && is_cand(m_acc)) ? (m_acc * 4) : 0;
      m_err = (ack && (int'(ack_lvl) != m_lvl)) ? 1 : 0;
      if (ack) m_acc = m_sel;
      bl = 7; bg = 0;
      for (int g = 2; g <= 30; g++)
        if (is_cand(g) && int'(lvl_v[g*LW +: LW]) < bl) begin
          bl = int'(lvl_v[g*LW +: LW]); bg = g;
        end
      m_sel = bg; m_lvl = bl;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    check({tag, " R4 level"}, int'(lvl_o), m_lvl);
    check({tag, " R9 err"}, int'(ack_err), m_err);
    check({tag, " R6 rdata"}, int'(rdata), m_rd);
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clr_all();
    req_v = '0; en_v = '0; lvl_v = '1;
    ack = 0; rd = 0; wr = 0;
  endtask

  task automatic set_grp(int g, int lv);
    req_v[g*SW +: SW] = 4'b0010;
    en_v[g*SW +: SW]  = 4'b0010;
    lvl_v[g*LW +: LW] = LW'(lv);
  endtask

  // drive the stimulus, wait one edge, then sample
  task automatic expect_lvl(string req, int exp);
    step();
    check(req, int'(lvl_o), exp);
  endtask

  task automatic do_ack(int lv);
    ack = 1; ack_lvl = LW'(lv);
    step();
    ack = 0;
  endtask

  task automatic do_read(int a, string req, int exp);
    rd = 1; rd_addr = a[0];
    step();
    rd = 0;
    check(req, int'(rdata), exp);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    // R10: reset values
    check("R10 lvl in reset", int'(lvl_o), 7);
    check("R10 rdata in reset", int'(rdata), 0);
    rst = 0;
    step();
    check("R10 lvl after reset", int'(lvl_o), 7);
    check("R10 err after reset", int'(ack_err), 0);
    do_read(0, "R10 accepted zero", 0);

    // R1: groups 0 and 1 ignored
    tag = "R1";
    req_v[7:0] = '1; en_v[7:0] = '1; lvl_v[5:0] = '0;
    expect_lvl("R1 low groups ignored", 7);
    // R1: request without enable is not a candidate
    clr_all();
    req_v[5*SW +: SW] = 4'b0100; en_v[5*SW +: SW] = 4'b1011; lvl_v[5*LW +: LW] = 3'd2;
    expect_lvl("R1 mismatched enable", 7);
    en_v[5*SW +: SW] = 4'b0100;
    expect_lvl("R1 matched enable", 2);

    // R2: best level and idle level
    tag = "R2";
    clr_all();
    set_grp(6, 4); set_grp(25, 2);
    expect_lvl("R2 smaller level wins", 2);
    clr_all();
    set_grp(12, 7);
    expect_lvl("R2 level-7 candidate", 7);

    // R3: tie goes to lowest group, then R5/R6 capture and read
    tag = "R3";
    clr_all();
    set_grp(20, 1); set_grp(9, 1);
    expect_lvl("R3 tie level", 1);
    do_ack(1);
    check("R9 matching ack no err", int'(ack_err), 0);
    do_read(0, "R3 R5 R6 tie lowest group", 36);

    // R7, R8
    tag = "R7";
    do_read(1, "R7 byte one zero", 0);
    wr = 1; wdata = 8'hFF; step(); wr = 0;
    do_read(0, "R8 write ignored", 36);

    // R9 mismatch
    tag = "R9";
    do_ack(5);
    check("R9 mismatch flag", int'(ack_err), 1);
    step();
    check("R9 single cycle", int'(ack_err), 0);

    // R6 lost request
    tag = "R6";
    req_v[9*SW +: SW] = '0;
    step();
    do_read(0, "R6 lost request", 0);

    // R5 boundary group 30
    tag = "R5";
    clr_all();
    set_grp(30, 0);
    expect_lvl("R5 top group level", 0);
    do_ack(0);
    do_read(0, "R5 top group captured", 120);
    clr_all();
    step();
    do_ack(7);
    do_read(0, "R5 idle ack captures zero", 0);

    // random traffic against the model
    tag = "RND";
    for (int i = 0; i < 2000; i++) begin
      for (int g = 0; g < NG; g++) begin
        if ($urandom_range(0, 7) == 0) begin
          req_v[g*SW +: SW] = SW'($urandom);
          en_v[g*SW +: SW]  = SW'($urandom);
          lvl_v[g*LW +: LW] = LW'($urandom);
        end
      end
      ack = ($urandom_range(0, 3) == 0);
      ack_lvl = ($urandom_range(0, 3) == 0) ? LW'($urandom) : LW'(m_lvl);
      rd = $urandom_range(0, 1) == 1;
      rd_addr = ($urandom_range(0, 5) == 0);
      wr = $urandom_range(0, 1) == 1;
      wdata = 8'($urandom);
      step();
    end
    ack = 0; rd = 0; wr = 0;
    step();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule